// File: doc/BRIEF.md
# Table-Driven Sixteen-Channel Trigger Evaluator

This block decides, on every valid sample of a 16-channel logic capture stream, whether a programmable trigger condition has been met. The channels are grouped into quads of four. The four bits of a quad address a 16-entry one-bit table. Three banks of such quad tables exist. The level bank implements a value/mask match. Each of two transition banks isolates one channel, so the bank's output follows that channel.

A 16-entry combining table looks at the present and previous outputs of both transition banks. It can therefore express rising, falling or either-edge conditions on one or two channels, or any other function of those four bits. Its result is ANDed with the level match. When the combined condition holds and the block is armed, it emits a single-cycle trigger pulse. It then disarms until software re-arms it.

All tables are written one row at a time. Row `i` supplies bit `i` of every table at once. Software that builds value/mask and edge conditions fills the tables and loads 16 rows before capture begins.

Top module: `lut_trigger_eval`

## Requirements
- R1: While and after reset the trigger output is low, the block is armed, and the history of both transition units is cleared. The level and transition tables reset to all ones, and the combining table resets to all zeros.
- R2: A table write with row index `r` sets bit `r` of every table. In the low write word, bit q (q = 0..3) is the level table of quad q, and bit 4 is the combining-table bit. In the high write word, bits 3:0 are the unit-0 quad tables and bits 7:4 are the unit-1 quad tables.
- R3: The level match is the AND over all quads of bit `sample[4q+3:4q]` of that quad's level table. Loaded with a value/mask pattern, it is 1 exactly when every masked channel equals its required value.
- R4: Each transition unit's current output is the AND over all quads of bit `sample[4q+3:4q]` of that unit's quad tables.
- R5: The combining table is indexed by a 4-bit value in which bit 2u is unit u's current output and bit 2u+1 is its output on the previous valid sample. A sample meets the trigger condition when the addressed combining bit and the level match are both 1.
- R6: Samples with `sample_valid_i` low never cause a trigger and do not update the transition history.
- R7: On the first valid sample after reset, each unit's previous output is taken equal to its current output, so no edge is seen on that sample.
- R8: The trigger output rises in the cycle after the qualifying sample, lasts one cycle, and stays low for later qualifying samples until re-armed.
- R9: Asserting `arm_i` in a cycle arms the block from the next cycle on, even if that same cycle produced a trigger.
- R10: After reset and before the combining table is loaded, no sample produces a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_valid_i | input | 1 | Qualifies `sample_i` this cycle |
| sample_i | input | 16 | Channel sample word |
| arm_i | input | 1 | Re-arms the trigger for the following cycles |
| tbl_wr_en_i | input | 1 | Writes one table row this cycle |
| tbl_row_i | input | 4 | Row (table bit index) being written |
| tbl_row_lo_i | input | 5 | Level quad bits [3:0], combining bit [4] |
| tbl_row_hi_i | input | 8 | Unit-0 quad bits [3:0], unit-1 quad bits [7:4] |
| trig_o | output | 1 | Single-cycle trigger pulse |

## Verification
The bench builds the block with its default four quads, which gives the full 16-bit sample space. A value/mask condition can therefore be swept across all 65536 sample words and compared against a direct per-channel compare. Rising, falling and OR-ed two-unit edge conditions are run over long pseudo-random streams with gaps in `sample_valid_i`. These runs reach the history rules, the first-sample case and the reset contents of the combining table. Short directed sequences with and without `arm_i` cover the disarm and re-arm ordering.

// File: rtl/lte_pkg.sv
package lte_pkg;
   localparam int QUAD_W    = 4;
   localparam int TBL_DEPTH = 1 << QUAD_W;
   localparam int ROW_W     = QUAD_W;
   localparam int N_UNITS   = 2;
   localparam int GLUE_W    = 2 * N_UNITS;

   typedef logic [TBL_DEPTH-1:0] tbl_t;
   typedef logic [ROW_W-1:0]     row_t;
endpackage

// File: rtl/lte_quad_bank.sv
module lte_quad_bank
   import lte_pkg::*;
#(
   parameter int   NUM_QUADS = 4,
   parameter logic RESET_BIT = 1'b1,
   localparam int  CH        = NUM_QUADS * QUAD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  row_t                 wr_row,
   input  logic [NUM_QUADS-1:0] wr_bits,
   input  logic [CH-1:0]        sample,
   output logic                 match_o
);
   tbl_t                 tbl_q [NUM_QUADS];
   logic [NUM_QUADS-1:0] quad_hit;

   generate
      for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tbl_q[q] <= {TBL_DEPTH{RESET_BIT}};
            end else if (wr_en) begin
               tbl_q[q][wr_row] <= wr_bits[q];
            end
         end

         assign quad_hit[q] = tbl_q[q][sample[q*QUAD_W +: QUAD_W]];

         AST_ROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> tbl_q[q][$past(wr_row)] == $past(wr_bits[q])); // R2
      end
   endgenerate

   assign match_o = &quad_hit;
endmodule

// File: rtl/lte_glue.sv
module lte_glue
   import lte_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  row_t              wr_row,
   input  logic              wr_bit,
   input  logic [GLUE_W-1:0] idx,
   output logic              hit_o
);
   tbl_t glue_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glue_q <= '0;
      end else if (wr_en) begin
         glue_q[wr_row] <= wr_bit;
      end
   end

   assign hit_o = glue_q[idx];

   AST_GLUE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> glue_q[$past(wr_row)] == $past(wr_bit)); // R2
endmodule

// File: rtl/lte_history.sv
module lte_history
   import lte_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  logic [N_UNITS-1:0] cur,
   output logic [N_UNITS-1:0] prev_eff_o
);
   logic [N_UNITS-1:0] prev_q;
   logic               seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         seen_q <= 1'b0;
      end else if (valid) begin
         prev_q <= cur;
         seen_q <= 1'b1;
      end
   end

   assign prev_eff_o = seen_q ? prev_q : cur;

   AST_PREV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> $stable(prev_q) && $stable(seen_q)); // R6
endmodule

// File: rtl/lut_trigger_eval.sv
module lut_trigger_eval
   import lte_pkg::*;
#(
   parameter int NUM_QUADS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sample_valid_i,
   input  logic [NUM_QUADS*4-1:0] sample_i,
   input  logic                   arm_i,
   input  logic                   tbl_wr_en_i,
   input  logic [3:0]             tbl_row_i,
   input  logic [NUM_QUADS:0]     tbl_row_lo_i,
   input  logic [2*NUM_QUADS-1:0] tbl_row_hi_i,
   output logic                   trig_o
);
   localparam int GLUE_BIT = NUM_QUADS;

   generate
      if (NUM_QUADS < 1 || NUM_QUADS > 4) begin : g_bad_quads
         $error("lut_trigger_eval: NUM_QUADS must be 1..4");
      end
      if (QUAD_W != 4 || GLUE_W != TBL_DEPTH / 4) begin : g_bad_shape
         $error("lut_trigger_eval: table shape mismatch");
      end
   endgenerate

   logic               lvl_hit;
   logic [N_UNITS-1:0] unit_cur;
   logic [N_UNITS-1:0] unit_prev;
   logic [GLUE_W-1:0]  glue_idx;
   logic               glue_hit;
   logic               fire;
   logic               armed_q;
   logic               trig_q;

   lte_quad_bank #(.NUM_QUADS(NUM_QUADS), .RESET_BIT(1'b1)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr_en_i),
      .wr_row  (tbl_row_i),
      .wr_bits (tbl_row_lo_i[NUM_QUADS-1:0]),
      .sample  (sample_i),
      .match_o (lvl_hit)
   );

   generate
      for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
         lte_quad_bank #(.NUM_QUADS(NUM_QUADS), .RESET_BIT(1'b1)) u_xbank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (tbl_wr_en_i),
            .wr_row  (tbl_row_i),
            .wr_bits (tbl_row_hi_i[u*NUM_QUADS +: NUM_QUADS]),
            .sample  (sample_i),
            .match_o (unit_cur[u])
         );
         assign glue_idx[2*u]   = unit_cur[u];
         assign glue_idx[2*u+1] = unit_prev[u];
      end
   endgenerate

   lte_history u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (sample_valid_i),
      .cur        (unit_cur),
      .prev_eff_o (unit_prev)
   );

   lte_glue u_glue (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr_en_i),
      .wr_row (tbl_row_i),
      .wr_bit (tbl_row_lo_i[GLUE_BIT]),
      .idx    (glue_idx),
      .hit_o  (glue_hit)
   );

   assign fire = sample_valid_i & armed_q & lvl_hit & glue_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         trig_q  <= 1'b0;
      end else begin
         trig_q  <= fire;
         armed_q <= arm_i | (armed_q & ~fire);
      end
   end

   assign trig_o = trig_q;

   AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_o && !$past(arm_i)) |=> !trig_o); // R8
   AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(sample_valid_i)); // R6
   AST_TRIG_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(lvl_hit)); // R3
   AST_TRIG_NEEDS_GLUE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> $past(glue_hit)); // R5
endmodule

// File: tb/lut_trigger_eval_tb_top.sv
`timescale 1ns/1ps
module lut_trigger_eval_tb_top;
   localparam int NQ = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid_i = 1'b0;
   logic [15:0] sample_i = '0;
   logic        arm_i = 1'b0;
   logic        tbl_wr_en_i = 1'b0;
   logic [3:0]  tbl_row_i = '0;
   logic [4:0]  tbl_row_lo_i = '0;
   logic [7:0]  tbl_row_hi_i = '0;
   logic        trig_o;

   always #2.5 clk = ~clk;

   lut_trigger_eval #(.NUM_QUADS(NQ)) dut_i (
      .clk(clk), .rst_n(rst_n), .sample_valid_i(sample_valid_i),
      .sample_i(sample_i), .arm_i(arm_i), .tbl_wr_en_i(tbl_wr_en_i),
      .tbl_row_i(tbl_row_i), .tbl_row_lo_i(tbl_row_lo_i),
      .tbl_row_hi_i(tbl_row_hi_i), .trig_o(trig_o)
   );

   int checks = 0;
   int fails  = 0;
   logic [3:0][15:0] lt, u0t, u1t;
   logic [15:0]      gl;
   logic             m_armed, m_seen;
   logic [1:0]       m_prev;
   logic [15:0]      rng = 16'hACE1;

   task automatic check(input logic ok, input string tag, input logic act, input logic exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [3:0][15:0] vm(input logic [15:0] val, input logic [15:0] msk);
      logic [3:0][15:0] t;
      for (int q = 0; q < 4; q++)
         for (int j = 0; j < 16; j++) begin
            t[q][j] = 1'b1;
            for (int k = 0; k < 4; k++)
               if (msk[4*q+k] && (val[4*q+k] != j[k])) t[q][j] = 1'b0;
         end
      return t;
   endfunction

   function automatic logic [15:0] edge_tbl(input int u, input logic rising);
      logic [15:0] g;
      for (int i = 0; i < 16; i++)
         g[i] = rising ? (i[2*u] && !i[2*u+1]) : (!i[2*u] && i[2*u+1]);
      return g;
   endfunction

   function automatic logic hit(input logic [3:0][15:0] t, input logic [15:0] s);
      logic r = 1'b1;
      for (int q = 0; q < 4; q++) r &= t[q][s[4*q +: 4]];
      return r;
   endfunction

   function automatic logic [15:0] next_rng(input logic [15:0] x);
      logic [15:0] y = x;
      y ^= y << 7; y ^= y >> 9; y ^= y << 8;
      return y;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(trig_o == 1'b0, "R1 reset trig", trig_o, 1'b0);
      rst_n = 1'b1;
      m_armed = 1'b1; m_seen = 1'b0; m_prev = '0;
      lt = '1; u0t = '1; u1t = '1; gl = '0;
   endtask

   task automatic load();
      for (int r = 0; r < 16; r++) begin
         tbl_wr_en_i = 1'b1;
         tbl_row_i   = r[3:0];
         for (int q = 0; q < 4; q++) begin
            tbl_row_lo_i[q]   = lt[q][r];
            tbl_row_hi_i[q]   = u0t[q][r];
            tbl_row_hi_i[q+4] = u1t[q][r];
         end
         tbl_row_lo_i[4] = gl[r];
         @(negedge clk);
      end
      tbl_wr_en_i = 1'b0;
   endtask

   task automatic step(input logic [15:0] s, input logic v, input logic a, input string tag);
      logic c0, c1, p0, p1, lv, exp;
      lv = hit(lt, s); c0 = hit(u0t, s); c1 = hit(u1t, s);
      p0 = m_seen ? m_prev[0] : c0;
      p1 = m_seen ? m_prev[1] : c1;
      exp = v & m_armed & lv & gl[{p1, c1, p0, c0}];
      m_armed = a | (m_armed & ~exp);
      if (v) begin m_prev = {c1, c0}; m_seen = 1'b1; end
      sample_i = s; sample_valid_i = v; arm_i = a;
      @(negedge clk);
      sample_valid_i = 1'b0; arm_i = 1'b0;
      check(trig_o == exp, tag, trig_o, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R10: combining table zero after reset, nothing fires
      for (int i = 0; i < 64; i++) begin
         rng = next_rng(rng);
         step(rng, 1'b1, 1'b1, "R10 unloaded glue");
      end

      // R3: exhaustive value/mask sweep
      do_reset();
      lt = vm(16'h0214, 16'h0F3C); gl = 16'hFFFF;
      load();
      for (int s = 0; s < 65536; s++) step(s[15:0], 1'b1, 1'b1, "R3 level sweep");

      // R2: second layout pattern across quads 0 and 3
      do_reset();
      lt = vm(16'h8001, 16'h8001); gl = 16'hFFFF;
      load();
      for (int i = 0; i < 512; i++) begin
         rng = next_rng(rng);
         step(rng, 1'b1, 1'b1, "R2 row layout");
      end

      // R7 then R4: rising on channel 5
      do_reset();
      u0t = vm(16'h0020, 16'h0020); gl = edge_tbl(0, 1'b1);
      load();
      step(16'hFFFF, 1'b1, 1'b1, "R7 first sample no edge");
      for (int i = 0; i < 600; i++) begin
         rng = next_rng(rng);
         step(rng, rng[3] | rng[11], 1'b1, "R4 rise unit0");
      end

      // R6: invalid samples ignored
      step(16'h0000, 1'b1, 1'b1, "R6 base low");
      step(16'h0020, 1'b0, 1'b1, "R6 invalid high");
      step(16'h0020, 1'b1, 1'b1, "R6 valid rise fires");
      step(16'h0000, 1'b0, 1'b1, "R6 invalid low");
      step(16'h0020, 1'b1, 1'b1, "R6 no rise after invalid");

      // R5: rise ch5 OR fall ch12, gated by level
      do_reset();
      lt  = vm(16'h0040, 16'h00C0);
      u0t = vm(16'h0020, 16'h0020);
      u1t = vm(16'h1000, 16'h1000);
      gl  = edge_tbl(0, 1'b1) | edge_tbl(1, 1'b0);
      load();
      for (int i = 0; i < 800; i++) begin
         rng = next_rng(rng);
         step(rng, rng[2] | rng[9], 1'b1, "R5 glue or level");
      end

      // R8 / R9: disarm and re-arm
      do_reset();
      gl = 16'hFFFF;
      load();
      step(16'h1234, 1'b1, 1'b0, "R8 first pulse");
      for (int i = 0; i < 5; i++) step(16'h4321, 1'b1, 1'b0, "R8 stays low");
      step(16'h0001, 1'b0, 1'b1, "R9 arm idle");
      step(16'h0002, 1'b1, 1'b1, "R9 fire with arm");
      step(16'h0003, 1'b1, 1'b0, "R9 armed by same-cycle arm");
      step(16'h0004, 1'b1, 1'b0, "R8 low after");

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule